// File: doc/BRIEF.md
# Merging Write Buffer

This block sits between a write-through cache and memory. It takes processor stores and keeps them in a few line-wide entries. Each entry has one line address and a valid bit for every word slot. A store to a line that already has a pending entry is folded into that entry. A store to a new line takes a free entry. The processor is stalled only when every entry is taken and the store matches none of the entries that can still accept data. Once the buffer accepts a store, the processor treats that store as finished.

Entries go to memory oldest first. Each one leaves as a single line write that carries a per-word enable mask, and the entry is released when memory acknowledges the write. Read misses are checked against the buffer at the same time. A read whose line is not held in the buffer may go straight to memory, ahead of pending writes, and while it does so no new drain is started. A read whose word is held in the buffer is answered from the buffer with the newest value. A read that hits a buffered line whose word is absent must wait.

Addresses are word addresses. The low bits pick the word slot and the remaining bits form the line address. The drain side is controlled by a two-state machine. `DS_IDLE` moves to `DS_SEND` when at least one entry is pending and no bypassing read is present in that cycle. `DS_SEND` drives the oldest entry onto the memory port and moves back to `DS_IDLE` in the cycle `mem_wack` is high.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer holds no entries: `st_ready` is 1, `mem_wvalid` is 0, and any read reports `rd_bypass`.
- R2: A store whose line matches an entry that is not being drained is written into that entry's word slot and sets that slot's valid bit. It uses no new entry, so four stores to the four words of one line drain as one write with `mem_wen` = 4'b1111.
- R3: A store to a word slot that is already valid replaces the older data; both a later read and the drained write return the newer value.
- R4: A store to a line with no matching entry takes a free entry. When all ENTRIES entries are in use and there is no match, `st_ready` is 0 and the store is not taken.
- R5: A store is taken, and is complete from the processor side, in the cycle in which `st_valid` and `st_ready` are both 1.
- R6: Entries drain in the order they were allocated. Each drain holds `mem_wvalid` high with a constant line address, data and mask until `mem_wack`, which releases the entry. `mem_wvalid` then drops in the next cycle.
- R7: A store whose line matches only the entry being drained is handled as a miss. It takes a new entry, or stalls when none is free.
- R8: A read miss whose line matches no valid entry gives `rd_bypass`. In a cycle with such a read, an idle drain side does not start, so `mem_wvalid` stays 0 in the next cycle.
- R9: A read miss whose word slot is valid in a matching entry gives `rd_hit`, with `rd_data` taken from the youngest entry that holds that word.
- R10: A read miss whose line matches an entry but whose word is valid in no matching entry gives `rd_wait`. Exactly one of `rd_bypass`, `rd_hit` and `rd_wait` is high whenever `rd_valid` is high.
- R11: Address bits [1:0] (the low log2(WORDS) bits) pick the word slot, and the upper bits are the line address on `mem_waddr`. Word i appears on `mem_wdata[i*DATA_W +: DATA_W]` and is enabled by `mem_wen[i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store request |
| st_addr | input | ADDR_W | Store word address |
| st_data | input | DATA_W | Store data |
| st_ready | output | 1 | Store can be taken this cycle |
| rd_valid | input | 1 | Read-miss lookup request |
| rd_addr | input | ADDR_W | Read-miss word address |
| rd_bypass | output | 1 | No conflict; the read may go to memory |
| rd_hit | output | 1 | Word supplied from the buffer |
| rd_wait | output | 1 | Conflict without the word; the read must wait |
| rd_data | output | DATA_W | Forwarded word when `rd_hit` |
| mem_wvalid | output | 1 | Line write request |
| mem_waddr | output | ADDR_W-log2(WORDS) | Line address of the write |
| mem_wdata | output | WORDS*DATA_W | Line data, word 0 in the low bits |
| mem_wen | output | WORDS | Per-word write enable |
| mem_wack | input | 1 | Memory accepts the write |

## Verification
The hardest case to reach is merging into an entry that has not started draining. The drain side leaves `DS_IDLE` one cycle after the first store, so a plain burst of stores to one line would mostly meet an entry that is already draining. The stimulus therefore holds a non-conflicting read on the read port while it issues stores, which keeps the drain side idle. This makes it possible to build multi-word entries, overwrite slots and fill every entry. The read is then released with `mem_wack` held low, so that stores arrive at the line being drained while the buffer is full. A long random phase then compares every output with a queue-based model on every clock.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;

    // Drain-side controller states
    typedef enum logic [0:0] {
        DS_IDLE = 1'b0,
        DS_SEND = 1'b1
    } drain_state_t;

endpackage

// File: rtl/merge_wbuf_entry.sv
module merge_wbuf_entry #(
    parameter int WORDS  = 4,
    parameter int DATA_W = 32,
    parameter int LINE_W = 14,
    parameter int OFF_W  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          alloc_i,
    input  logic                          merge_i,
    input  logic                          free_i,
    input  logic [LINE_W-1:0]             line_i,
    input  logic [OFF_W-1:0]              word_i,
    input  logic [DATA_W-1:0]             data_i,
    output logic                          busy_o,
    output logic [LINE_W-1:0]             line_o,
    output logic [WORDS-1:0]              wmask_o,
    output logic [WORDS-1:0][DATA_W-1:0]  data_o
);

    logic [WORDS-1:0] slot_sel;

    assign slot_sel = WORDS'(1) << word_i;

    // Control state: occupancy, line tag, per-word valid bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_o  <= 1'b0;
            line_o  <= '0;
            wmask_o <= '0;
        end else if (free_i) begin
            busy_o  <= 1'b0;
            wmask_o <= '0;
        end else if (alloc_i) begin
            busy_o  <= 1'b1;
            line_o  <= line_i;
            wmask_o <= slot_sel;
        end else if (merge_i) begin
            wmask_o <= wmask_o | slot_sel;
        end
    end

    // Data slots: meaningful only where the mask bit is set
    always_ff @(posedge clk) begin
        if (alloc_i || merge_i) begin
            data_o[word_i] <= data_i;
        end
    end

endmodule

// File: rtl/merge_wbuf_lookup.sv
module merge_wbuf_lookup #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int LINE_W  = 14,
    parameter int OFF_W   = 2,
    parameter int PTR_W   = 2
) (
    input  logic [ENTRIES-1:0]                         ent_valid,
    input  logic [ENTRIES-1:0][LINE_W-1:0]             ent_line,
    input  logic [ENTRIES-1:0][WORDS-1:0]              ent_mask,
    input  logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0]  ent_data,
    input  logic [PTR_W-1:0]                           oldest,
    input  logic [LINE_W-1:0]                          q_line,
    input  logic [OFF_W-1:0]                           q_word,
    output logic                                       conflict_o,
    output logic                                       hit_o,
    output logic [DATA_W-1:0]                          data_o
);

    // Walk entries oldest to youngest; the last holder of the word wins.
    always_comb begin
        logic [PTR_W-1:0] idx;
        idx        = '0;
        conflict_o = 1'b0;
        hit_o      = 1'b0;
        data_o     = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            idx = PTR_W'((int'(oldest) + k) % ENTRIES);
            if (ent_valid[idx] && (ent_line[idx] == q_line)) begin
                conflict_o = 1'b1;
                if (ent_mask[idx][q_word]) begin
                    hit_o  = 1'b1;
                    data_o = ent_data[idx][q_word];
                end
            end
        end
    end

endmodule

// File: rtl/merge_wbuf_drain.sv
module merge_wbuf_drain
    import merge_wbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    input  logic hold_i,
    input  logic ack_i,
    output logic send_o,
    output logic pop_o
);

    drain_state_t state_q;
    drain_state_t state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DS_IDLE: if (pending_i && !hold_i) state_d = DS_SEND;
            DS_SEND: if (ack_i)                state_d = DS_IDLE;
            default: state_d = DS_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        send_o = 1'b0;
        pop_o  = 1'b0;
        unique case (state_q)
            DS_IDLE: ;
            DS_SEND: begin
                send_o = 1'b1;
                pop_o  = ack_i;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 16,
    localparam int OFF_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int LINE_W = ADDR_W - OFF_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     st_valid,
    input  logic [ADDR_W-1:0]        st_addr,
    input  logic [DATA_W-1:0]        st_data,
    output logic                     st_ready,
    input  logic                     rd_valid,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic                     rd_bypass,
    output logic                     rd_hit,
    output logic                     rd_wait,
    output logic [DATA_W-1:0]        rd_data,
    output logic                     mem_wvalid,
    output logic [LINE_W-1:0]        mem_waddr,
    output logic [WORDS*DATA_W-1:0]  mem_wdata,
    output logic [WORDS-1:0]         mem_wen,
    input  logic                     mem_wack
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int CNT_W = $clog2(ENTRIES + 1);

    logic [ENTRIES-1:0]                         ent_valid;
    logic [ENTRIES-1:0][LINE_W-1:0]             ent_line;
    logic [ENTRIES-1:0][WORDS-1:0]              ent_mask;
    logic [ENTRIES-1:0][WORDS-1:0][DATA_W-1:0]  ent_data;
    logic [ENTRIES-1:0]                         match_vec;

    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;
    logic [CNT_W-1:0] occ_q;

    logic [LINE_W-1:0] st_line;
    logic [OFF_W-1:0]  st_word;
    logic [LINE_W-1:0] rd_line;
    logic [OFF_W-1:0]  rd_word;

    logic merge_hit;
    logic has_room;
    logic st_take;
    logic do_alloc;
    logic sending;
    logic pop;
    logic rd_conflict;
    logic rd_found;

    assign st_line = st_addr[ADDR_W-1:OFF_W];
    assign st_word = st_addr[OFF_W-1:0];
    assign rd_line = rd_addr[ADDR_W-1:OFF_W];
    assign rd_word = rd_addr[OFF_W-1:0];

    // Per-entry storage and store-side match (draining entry excluded)
    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        assign match_vec[i] = ent_valid[i] && (ent_line[i] == st_line) &&
                              !(sending && (head_q == PTR_W'(i)));

        merge_wbuf_entry #(
            .WORDS  (WORDS),
            .DATA_W (DATA_W),
            .LINE_W (LINE_W),
            .OFF_W  (OFF_W)
        ) u_entry (
            .clk     (clk),
            .rst_n   (rst_n),
            .alloc_i (do_alloc && (tail_q == PTR_W'(i))),
            .merge_i (st_take && match_vec[i]),
            .free_i  (pop && (head_q == PTR_W'(i))),
            .line_i  (st_line),
            .word_i  (st_word),
            .data_i  (st_data),
            .busy_o  (ent_valid[i]),
            .line_o  (ent_line[i]),
            .wmask_o (ent_mask[i]),
            .data_o  (ent_data[i])
        );
    end

    assign merge_hit = |match_vec;
    assign has_room  = occ_q < CNT_W'(ENTRIES);
    assign st_ready  = merge_hit || has_room;
    assign st_take   = st_valid && st_ready;
    assign do_alloc  = st_take && !merge_hit;

    // Ring pointers and occupancy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (do_alloc) begin
                tail_q <= (tail_q == PTR_W'(ENTRIES - 1)) ? '0 : tail_q + 1'b1;
            end
            if (pop) begin
                head_q <= (head_q == PTR_W'(ENTRIES - 1)) ? '0 : head_q + 1'b1;
            end
            occ_q <= occ_q + CNT_W'(do_alloc) - CNT_W'(pop);
        end
    end

    // Read-miss check
    merge_wbuf_lookup #(
        .ENTRIES (ENTRIES),
        .WORDS   (WORDS),
        .DATA_W  (DATA_W),
        .LINE_W  (LINE_W),
        .OFF_W   (OFF_W),
        .PTR_W   (PTR_W)
    ) u_lookup (
        .ent_valid  (ent_valid),
        .ent_line   (ent_line),
        .ent_mask   (ent_mask),
        .ent_data   (ent_data),
        .oldest     (head_q),
        .q_line     (rd_line),
        .q_word     (rd_word),
        .conflict_o (rd_conflict),
        .hit_o      (rd_found),
        .data_o     (rd_data)
    );

    assign rd_bypass = rd_valid && !rd_conflict;
    assign rd_hit    = rd_valid && rd_conflict && rd_found;
    assign rd_wait   = rd_valid && rd_conflict && !rd_found;

    // Drain sequencing
    merge_wbuf_drain u_drain (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (occ_q != '0),
        .hold_i    (rd_bypass),
        .ack_i     (mem_wack),
        .send_o    (sending),
        .pop_o     (pop)
    );

    assign mem_wvalid = sending;
    assign mem_waddr  = ent_line[head_q];
    assign mem_wen    = ent_mask[head_q];
    assign mem_wdata  = ent_data[head_q];

endmodule

// File: rtl/merge_wbuf_checker.sv
module merge_wbuf_checker #(
    parameter int ENTRIES = 4,
    parameter int WORDS   = 4,
    parameter int DATA_W  = 32,
    parameter int LINE_W  = 14,
    parameter int CNT_W   = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic                    rd_valid,
    input logic                    rd_bypass,
    input logic                    rd_hit,
    input logic                    rd_wait,
    input logic                    mem_wvalid,
    input logic [LINE_W-1:0]       mem_waddr,
    input logic [WORDS*DATA_W-1:0] mem_wdata,
    input logic [WORDS-1:0]        mem_wen,
    input logic                    mem_wack,
    input logic [CNT_W-1:0]        occ
);

    AST_STALL_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !st_ready |-> (occ == CNT_W'(ENTRIES)));  // R4

    AST_OCC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(ENTRIES));  // R4

    AST_DRAIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && !mem_wack) |=> (mem_wvalid && $stable(mem_waddr) &&
                                       $stable(mem_wen) && $stable(mem_wdata)));  // R6

    AST_ACK_ENDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wvalid && mem_wack) |=> !mem_wvalid);  // R6

    AST_WEN_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wvalid |-> (mem_wen != '0));  // R2

    AST_BYPASS_HOLDS_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_wvalid && rd_bypass) |=> !mem_wvalid);  // R8

    AST_READ_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($countones({rd_bypass, rd_hit, rd_wait}) == 1));  // R10

    AST_READ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> ($countones({rd_bypass, rd_hit, rd_wait}) == 0));  // R10

    AST_EMPTY_NEVER_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == '0) |-> st_ready);  // R1

endmodule

bind merge_wbuf merge_wbuf_checker #(
    .ENTRIES (ENTRIES),
    .WORDS   (WORDS),
    .DATA_W  (DATA_W),
    .LINE_W  (LINE_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .rd_valid   (rd_valid),
    .rd_bypass  (rd_bypass),
    .rd_hit     (rd_hit),
    .rd_wait    (rd_wait),
    .mem_wvalid (mem_wvalid),
    .mem_waddr  (mem_waddr),
    .mem_wdata  (mem_wdata),
    .mem_wen    (mem_wen),
    .mem_wack   (mem_wack),
    .occ        (occ_q)
);

// File: tb/merge_wbuf_tb.sv
`timescale 1ns/1ps
module merge_wbuf_tb;

    localparam int N  = 4;
    localparam int W  = 4;
    localparam int DW = 32;
    localparam int AW = 16;
    localparam int LW = AW - 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            st_valid = 1'b0;
    logic [AW-1:0]   st_addr = '0;
    logic [DW-1:0]   st_data = '0;
    logic            st_ready;
    logic            rd_valid = 1'b0;
    logic [AW-1:0]   rd_addr = '0;
    logic            rd_bypass, rd_hit, rd_wait;
    logic [DW-1:0]   rd_data;
    logic            mem_wvalid;
    logic [LW-1:0]   mem_waddr;
    logic [W*DW-1:0] mem_wdata;
    logic [W-1:0]    mem_wen;
    logic            mem_wack = 1'b0;

    int total = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    merge_wbuf u_dut (.*);

    // Behavioural reference: queue of pending lines, oldest first
    typedef struct {
        logic [LW-1:0]      line;
        logic [W-1:0]       m;
        logic [W-1:0][DW-1:0] d;
    } ent_t;
    ent_t q[$];
    bit   busy = 0;

    task automatic chk(string tag, string what, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(bit sv, logic [AW-1:0] sa, logic [DW-1:0] sd,
                         bit rv, logic [AW-1:0] ra, bit ack);
        st_valid = sv; st_addr = sa; st_data = sd;
        rd_valid = rv; rd_addr = ra; mem_wack = ack;
    endtask

    function automatic logic [AW-1:0] wa(int line, int word);
        return AW'(line * W + word);
    endfunction

    // Compare every output with the model, advance the model, move to next negedge
    task automatic step();
        int mi, sz0;
        bit exp_ready, conf, hit, take, nbusy;
        logic [DW-1:0] hdata;
        logic [LW-1:0] sl, rl;
        logic [1:0] sw, rw;
        logic [127:0] msk;
        ent_t e;
        #1;
        sl = st_addr[AW-1:2]; sw = st_addr[1:0];
        rl = rd_addr[AW-1:2]; rw = rd_addr[1:0];
        mi = -1;
        for (int i = (busy ? 1 : 0); i < q.size(); i++)
            if (q[i].line == sl) mi = i;
        exp_ready = (mi >= 0) || (q.size() < N);
        conf = 0; hit = 0; hdata = '0;
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].line == rl) begin
                conf = 1;
                if (q[i].m[rw]) begin hit = 1; hdata = q[i].d[rw]; end
            end
        end
        chk("R4", "st_ready", 128'(st_ready), 128'(exp_ready));
        chk("R8", "rd_bypass", 128'(rd_bypass), 128'(rd_valid && !conf));
        chk("R9", "rd_hit", 128'(rd_hit), 128'(rd_valid && hit));
        chk("R10", "rd_wait", 128'(rd_wait), 128'(rd_valid && conf && !hit));
        if (rd_valid && hit) chk("R9", "rd_data", 128'(rd_data), 128'(hdata));
        chk("R6", "mem_wvalid", 128'(mem_wvalid), 128'(busy));
        if (busy) begin
            chk("R6", "mem_waddr", 128'(mem_waddr), 128'(q[0].line));
            chk("R2", "mem_wen", 128'(mem_wen), 128'(q[0].m));
            msk = '0;
            for (int k = 0; k < W; k++) if (q[0].m[k]) msk[k*DW +: DW] = '1;
            chk("R11", "mem_wdata", 128'(mem_wdata) & msk, 128'(q[0].d) & msk);
        end
        // Model update (what the next edge does)
        sz0  = q.size();
        take = st_valid && exp_ready;  // R5
        if (take) begin
            if (mi >= 0) begin
                q[mi].m[sw] = 1'b1;
                q[mi].d[sw] = st_data;  // R3: newer data replaces older
            end else begin
                e.line = sl; e.m = '0; e.d = '0;
                e.m[sw] = 1'b1; e.d[sw] = st_data;
                q.push_back(e);
            end
        end
        if (busy) nbusy = !mem_wack;
        else      nbusy = (sz0 != 0) && !(rd_valid && !conf);
        if (busy && mem_wack) void'(q.pop_front());
        busy = nbusy;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            total++; fails++;
            $display("FAIL R6 watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        drive(0, '0, '0, 1, wa(7, 0), 0);
        #0.5;
        chk("R1", "st_ready", 128'(st_ready), 128'(1));
        chk("R1", "mem_wvalid", 128'(mem_wvalid), 128'(0));
        chk("R1", "rd_bypass", 128'(rd_bypass), 128'(1));
        step();

        // R2/R5/R8: merge four words into one line while a clear read holds the drain
        for (int k = 0; k < W; k++) begin
            drive(1, wa(3, k), 32'hA000_0000 + k, 1, wa(9, 0), 0);
            #0.5;
            chk("R5", "st_ready on merge", 128'(st_ready), 128'(1));
            step();
        end
        // R3: overwrite word 1 of line 5
        drive(1, wa(5, 1), 32'h1111_1111, 1, wa(9, 0), 0); step();
        drive(1, wa(5, 1), 32'h2222_2222, 1, wa(9, 0), 0); step();
        drive(0, '0, '0, 1, wa(5, 1), 0);
        #0.5;
        chk("R3", "forwarded newest", 128'(rd_data), 128'(32'h2222_2222));
        step();
        // R10: word absent in a buffered line
        drive(0, '0, '0, 1, wa(5, 3), 0);
        #0.5;
        chk("R10", "rd_wait absent word", 128'(rd_wait), 128'(1));
        step();
        // R4: fill remaining entries, then a new line stalls
        drive(1, wa(6, 0), 32'h6, 1, wa(9, 0), 0); step();
        drive(1, wa(8, 2), 32'h8, 1, wa(9, 0), 0); step();
        drive(1, wa(10, 0), 32'hA, 1, wa(9, 0), 0);
        #0.5;
        chk("R4", "stall when full", 128'(st_ready), 128'(0));
        step();
        drive(1, wa(6, 3), 32'h63, 1, wa(9, 0), 0);
        #0.5;
        chk("R2", "merge while full", 128'(st_ready), 128'(1));
        step();
        // R7: release hold, no ack; store to the draining line stalls while full
        drive(0, '0, '0, 0, '0, 0); step();
        drive(1, wa(3, 0), 32'hBEEF, 0, '0, 0);
        #0.5;
        chk("R7", "no merge into draining", 128'(st_ready), 128'(0));
        chk("R6", "draining line", 128'(mem_waddr), 128'(3));
        step();
        drive(0, '0, '0, 0, '0, 1); step();
        drive(1, wa(3, 0), 32'hBEEF, 0, '0, 0);
        #0.5;
        chk("R7", "new entry after drain", 128'(st_ready), 128'(1));
        step();
        // Drain everything
        for (int c = 0; c < 30; c++) begin
            drive(0, '0, '0, 0, '0, 1); step();
        end

        // Random phase
        for (int c = 0; c < 6000; c++) begin
            drive($urandom_range(0, 1), wa($urandom_range(0, 5), $urandom_range(0, 3)),
                  $urandom, ($urandom_range(0, 2) == 0),
                  wa($urandom_range(0, 6), $urandom_range(0, 3)),
                  (c % 400 < 200) ? ($urandom_range(0, 5) == 0) : ($urandom_range(0, 1) == 1));
            step();
        end

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule